// File: doc/BRIEF.md
# Single-Entry Data Cache Store Buffer

This block sits between the store path of a pipeline and a single-ported data cache array. A store is written into one holding register, which keeps its doubleword address, 64-bit data and byte enables. The tag of that store is compared in the same cycle, and the compare result arrives on `tag_hit`. If the tag misses, the block drops the entry and raises `st_miss` for the rest of the pipeline to handle. If the tag hits, the entry waits for a cycle in which no load is using the array, and then writes itself into the array.

Because the entry never waits for a free slot, the pipeline can issue a store on every cycle. If a store finds an older hit entry still pending, the older entry is written to the array in that same cycle, and the new store takes its place.

A load to the pending entry's address is not stalled. In that cycle the array port reads and writes the same location. The load gets the array data with the buffered bytes laid over it, and the buffered bytes are committed to the array at the clock edge.

Top module: `stbuf_single`

## Requirements
- R1: After reset the buffer is empty. In any cycle with no load and no pending entry, `arr_en` is 0.
- R2: A store with `tag_hit`=1 is captured. In the next cycle that has no load, the block drives `arr_en`=1, `arr_we`=1, and puts that store's address, data and byte enables on `arr_addr`, `arr_wdata` and `arr_wbe`.
- R3: A store with `tag_hit`=0 raises `st_miss` in the same cycle. Its data never reaches the array, and it leaves the buffer empty.
- R4: A load to an address other than the pending one reads the array with `arr_en`=1, `arr_we`=0 and `arr_addr`=`ld_addr`, and returns `arr_rdata` unchanged on `ld_data`. The pending entry is kept for a later non-load cycle.
- R5: A store that arrives while a hit entry is pending causes the older entry to be written to the array in that same cycle. Stores need no stall.
- R6: A load whose address equals the pending entry's address does two things in the same cycle. It writes the entry to the array (`arr_we`=1, `arr_addr`=`ld_addr`). It also returns, on `ld_data`, byte i taken from the buffer when byte enable bit i is 1 and from `arr_rdata` otherwise, where byte i is data bits [8i+7:8i]. After that cycle the buffer is empty.
- R7: Every load returns the most recent data written by hit stores to that address, in program order, and after a drain the array holds the same contents.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| st_valid | input | 1 | Store issued this cycle |
| st_addr | input | ADDR_W | Doubleword address of the store |
| st_data | input | DATA_W | Store data |
| st_be | input | DATA_W/8 | Store byte enables; bit i covers data bits [8i+7:8i] |
| tag_hit | input | 1 | Tag compare result for this cycle's store |
| st_miss | output | 1 | Store tag missed; the entry is dropped |
| ld_valid | input | 1 | Load issued this cycle |
| ld_addr | input | ADDR_W | Doubleword address of the load |
| ld_data | output | DATA_W | Load return data, merged with the pending store |
| arr_en | output | 1 | Array access enable |
| arr_we | output | 1 | Array write enable |
| arr_addr | output | ADDR_W | Array address |
| arr_wdata | output | DATA_W | Array write data |
| arr_wbe | output | DATA_W/8 | Array byte write enables |
| arr_rdata | input | DATA_W | Array read data, available combinationally in the cycle of the access |

## Verification
The assertions assume that the pipeline never issues a load and a store in the same cycle. They also assume that the array returns read data in the same cycle as the access and commits writes at the clock edge. One assertion watches for a load and a store arriving together.

The bench keeps its stimulus inside these limits. Its array model reads combinationally and writes on the edge. Each cycle of its generated traffic is a store, a load or an idle cycle, never a load and a store together.

// File: rtl/stbuf_single.sv
module stbuf_single #(
  parameter int ADDR_W = 10,
  parameter int DATA_W = 64
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  st_valid,
  input  logic [ADDR_W-1:0]     st_addr,
  input  logic [DATA_W-1:0]     st_data,
  input  logic [DATA_W/8-1:0]   st_be,
  input  logic                  tag_hit,
  output logic                  st_miss,
  input  logic                  ld_valid,
  input  logic [ADDR_W-1:0]     ld_addr,
  output logic [DATA_W-1:0]     ld_data,
  output logic                  arr_en,
  output logic                  arr_we,
  output logic [ADDR_W-1:0]     arr_addr,
  output logic [DATA_W-1:0]     arr_wdata,
  output logic [DATA_W/8-1:0]   arr_wbe,
  input  logic [DATA_W-1:0]     arr_rdata
);
  localparam int BE_W = DATA_W / 8;

  logic              buf_v;
  logic [ADDR_W-1:0] buf_addr;
  logic [DATA_W-1:0] buf_data;
  logic [BE_W-1:0]   buf_be;

  logic ld_hit, drain;

  assign ld_hit = ld_valid && buf_v && (ld_addr == buf_addr);
  assign drain  = buf_v && (!ld_valid || ld_hit);

  assign st_miss   = st_valid && !tag_hit;
  assign arr_en    = ld_valid || buf_v;
  assign arr_we    = drain;
  assign arr_addr  = ld_valid ? ld_addr : buf_addr;
  assign arr_wdata = buf_data;
  assign arr_wbe   = buf_be;

  for (genvar i = 0; i < BE_W; i++) begin : g_merge
    assign ld_data[8*i +: 8] = (ld_hit && buf_be[i]) ? buf_data[8*i +: 8]
                                                     : arr_rdata[8*i +: 8];
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      buf_v <= 1'b0;
    end else if (st_valid && tag_hit) begin
      buf_v    <= 1'b1;
      buf_addr <= st_addr;
      buf_data <= st_data;
      buf_be   <= st_be;
    end else if (drain || st_valid) begin
      buf_v <= 1'b0;
    end
  end
endmodule

// File: rtl/stbuf_single_chk.sv
module stbuf_single_chk #(
  parameter int ADDR_W = 10,
  parameter int DATA_W = 64
) (
  input logic                clk,
  input logic                rst_n,
  input logic                st_valid,
  input logic [ADDR_W-1:0]   st_addr,
  input logic                tag_hit,
  input logic                st_miss,
  input logic                ld_valid,
  input logic [ADDR_W-1:0]   ld_addr,
  input logic                arr_en,
  input logic                arr_we,
  input logic [ADDR_W-1:0]   arr_addr,
  input logic [DATA_W-1:0]   arr_wdata,
  input logic                buf_v,
  input logic [ADDR_W-1:0]   buf_addr,
  input logic [DATA_W-1:0]   buf_data
);
  // input assumption: one memory operation per cycle
  a_in_one_op: assert property (@(posedge clk) disable iff (!rst_n)
    !(st_valid && ld_valid));

  a_r1_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    (!buf_v && !ld_valid) |-> !arr_en);

  a_r2_capture: assert property (@(posedge clk) disable iff (!rst_n)
    (st_valid && tag_hit) |=> (buf_v && buf_addr == $past(st_addr)));

  a_r2_drain_free: assert property (@(posedge clk) disable iff (!rst_n)
    (buf_v && !ld_valid) |-> (arr_en && arr_we && arr_addr == buf_addr && arr_wdata == buf_data));

  a_r3_miss_drops: assert property (@(posedge clk) disable iff (!rst_n)
    (st_valid && !tag_hit) |=> !buf_v);

  a_r3_miss_flag: assert property (@(posedge clk) disable iff (!rst_n)
    st_miss |-> st_valid);

  a_r4_load_reads: assert property (@(posedge clk) disable iff (!rst_n)
    ld_valid |-> (arr_en && arr_addr == ld_addr));

  a_r4_keep: assert property (@(posedge clk) disable iff (!rst_n)
    (ld_valid && buf_v && ld_addr != buf_addr) |-> (!arr_we ##1 buf_v));

  a_r6_combined: assert property (@(posedge clk) disable iff (!rst_n)
    (ld_valid && buf_v && ld_addr == buf_addr) |-> (arr_we && arr_wdata == buf_data) ##1 !buf_v);
endmodule

bind stbuf_single stbuf_single_chk #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .st_valid(st_valid), .st_addr(st_addr), .tag_hit(tag_hit),
  .st_miss(st_miss), .ld_valid(ld_valid), .ld_addr(ld_addr), .arr_en(arr_en),
  .arr_we(arr_we), .arr_addr(arr_addr), .arr_wdata(arr_wdata), .buf_v(buf_v),
  .buf_addr(buf_addr), .buf_data(buf_data)
);

// File: tb/tb_stbuf_single.sv
`timescale 1ns/1ps
module tb_stbuf_single;
  localparam int AW = 3;
  localparam int DW = 64;
  localparam int BW = DW / 8;
  localparam int NW = 1 << AW;

  logic clk = 1'b0, rst_n = 1'b0;
  logic st_valid = 0, tag_hit = 0, ld_valid = 0;
  logic [AW-1:0] st_addr = '0, ld_addr = '0;
  logic [DW-1:0] st_data = '0;
  logic [BW-1:0] st_be = '0;
  logic st_miss, arr_en, arr_we;
  logic [AW-1:0] arr_addr;
  logic [DW-1:0] ld_data, arr_wdata, arr_rdata;
  logic [BW-1:0] arr_wbe;

  logic [DW-1:0] mem [NW];
  logic [DW-1:0] gold [NW];
  int checks = 0, errors = 0, cyc = 0;

  always #2 clk = ~clk;

  stbuf_single #(.ADDR_W(AW), .DATA_W(DW)) dut (
    .clk(clk), .rst_n(rst_n), .st_valid(st_valid), .st_addr(st_addr), .st_data(st_data),
    .st_be(st_be), .tag_hit(tag_hit), .st_miss(st_miss), .ld_valid(ld_valid),
    .ld_addr(ld_addr), .ld_data(ld_data), .arr_en(arr_en), .arr_we(arr_we),
    .arr_addr(arr_addr), .arr_wdata(arr_wdata), .arr_wbe(arr_wbe), .arr_rdata(arr_rdata));

  assign arr_rdata = mem[arr_addr];

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (arr_en && arr_we)
      for (int i = 0; i < BW; i++)
        if (arr_wbe[i]) mem[arr_addr][8*i +: 8] <= arr_wdata[8*i +: 8];
    if (cyc > 150000) begin
      errors = errors + 1;
      $display("FAIL watchdog expired");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  task automatic chk(input bit ok, input string req, input logic [DW-1:0] act, input logic [DW-1:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [DW-1:0] apply(input logic [DW-1:0] old, input logic [DW-1:0] d, input logic [BW-1:0] be);
    logic [DW-1:0] r = old;
    for (int i = 0; i < BW; i++) if (be[i]) r[8*i +: 8] = d[8*i +: 8];
    return r;
  endfunction

  // drive one cycle at the falling edge; outputs are checked 1 ns later
  task automatic drive(input bit sv, input logic [AW-1:0] sa, input logic [DW-1:0] sd,
                       input logic [BW-1:0] sbe, input bit hit, input bit lv, input logic [AW-1:0] la);
    @(negedge clk);
    st_valid = sv; st_addr = sa; st_data = sd; st_be = sbe; tag_hit = hit;
    ld_valid = lv; ld_addr = la;
    #1;
    if (lv) chk(ld_data == gold[la], "R7 load value", ld_data, gold[la]);
    if (sv) chk(st_miss == !hit, "R3 miss flag", DW'(st_miss), DW'(!hit));
    if (sv && hit) gold[sa] = apply(gold[sa], sd, sbe);
  endtask

  task automatic idle(); drive(0, '0, '0, '0, 0, 0, '0); endtask

  initial begin
    for (int i = 0; i < NW; i++) begin
      mem[i] = {32'hC0DE_0000 + 32'(i), 32'h1234_5670 + 32'(i)};
      gold[i] = mem[i];
    end
    repeat (3) @(posedge clk);
    @(negedge clk); rst_n = 1'b1;
    #1 chk(arr_en == 0, "R1 reset idle", DW'(arr_en), 0);

    // R2: capture then drain on a free cycle
    drive(1, 3'd2, 64'h1111_2222_3333_4444, 8'hF0, 1, 0, '0);
    idle();
    chk(arr_en && arr_we && arr_addr == 3'd2 && arr_wdata == 64'h1111_2222_3333_4444 && arr_wbe == 8'hF0,
        "R2 drain", {arr_wbe, 53'(arr_addr), arr_we, arr_en}, {8'hF0, 53'd2, 1'b1, 1'b1});
    idle();
    chk(arr_en == 0, "R1 empty idle", DW'(arr_en), 0);

    // R3: miss drops entry
    drive(1, 3'd5, 64'hDEAD_BEEF_DEAD_BEEF, 8'hFF, 0, 0, '0);
    idle();
    chk(arr_en == 0, "R3 no drain after miss", DW'(arr_en), 0);

    // R5: back-to-back stores
    drive(1, 3'd1, 64'hAAAA_0000_0000_0001, 8'hFF, 1, 0, '0);
    drive(1, 3'd3, 64'hBBBB_0000_0000_0003, 8'h0F, 1, 0, '0);
    chk(arr_we && arr_addr == 3'd1 && arr_wdata == 64'hAAAA_0000_0000_0001, "R5 older drains",
        arr_wdata, 64'hAAAA_0000_0000_0001);

    // R4: load elsewhere keeps entry
    drive(0, '0, '0, '0, 0, 1, 3'd6);
    chk(arr_en && !arr_we && arr_addr == 3'd6 && ld_data == mem[6], "R4 plain read", ld_data, mem[6]);
    idle();
    chk(arr_we && arr_addr == 3'd3 && arr_wbe == 8'h0F, "R4 later drain", DW'(arr_addr), 3);

    // R6: store then load same address
    drive(1, 3'd4, 64'h0102_0304_0506_0708, 8'h3C, 1, 0, '0);
    drive(0, '0, '0, '0, 0, 1, 3'd4);
    chk(arr_we && arr_addr == 3'd4 && arr_wbe == 8'h3C, "R6 combined write", DW'(arr_wbe), 64'h3C);
    idle();
    chk(arr_en == 0, "R6 buffer emptied", DW'(arr_en), 0);

    // sweep: every store/load address pair, several byte patterns
    for (int sa = 0; sa < NW; sa++)
      for (int la = 0; la < NW; la++)
        for (int p = 0; p < 5; p++) begin
          logic [BW-1:0] be;
          case (p) 0: be = 8'h00; 1: be = 8'hFF; 2: be = 8'h0F; 3: be = 8'hA5; default: be = 8'h80; endcase
          drive(1, AW'(sa), {32'(sa * 977 + p), 32'(la * 31337 + p)}, be, 1, 0, '0);
          drive(0, '0, '0, '0, 0, 1, AW'(la));   // R6 when sa==la, R4 otherwise
          if (p == 4) idle();
        end

    // mixed traffic
    for (int n = 0; n < 4000; n++) begin
      int op = $urandom_range(0, 9);
      if (op < 4) drive(1, AW'($urandom), {$urandom, $urandom}, BW'($urandom), op != 0, 0, '0);
      else if (op < 8) drive(0, '0, '0, '0, 0, 1, AW'($urandom));
      else idle();
    end
    idle(); idle();
    for (int i = 0; i < NW; i++) chk(mem[i] == gold[i], "R7 array contents", mem[i], gold[i]);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule